// File: doc/BRIEF.md
# Local bus transaction error monitor

This block sits beside the controller of an external memory bus that is split into several banks. It watches each transaction the host starts: which bank the address selects, whether it writes, whether it is an atomic access, and whether a data beat is acknowledged in time. When something goes wrong it raises a flag in a sticky status register. The flags cover a missing acknowledge, a broken atomic read/write pairing, an address outside every bank, a write into a read-only bank and a parity error. Three more flags report that a run-pattern operation has finished, that a flash command has finished, and that a flash command has run over its own time limit.

Each bank is set by a base, a mask and a read-only bit on static configuration inputs. A register port with four word offsets reads and clears the flags, holds per-flag interrupt enables and the acknowledge limit, and shows which byte lane and bank the first parity error came from. The interrupt output is the enabled flags ORed together.

Top module: `lbus_err_mon`

## Requirements
- R1: A transaction whose address satisfies `(addr & mask) == base` for no bank sets status bit 6 on the clock edge that samples `txn_start`.
- R2: When several banks match, the lowest-numbered bank is the one selected. Its read-only bit and its index are the ones used.
- R3: A write whose selected bank has its `bank_ro` bit set sets status bit 3. A read of that bank, or a write to a writable bank, leaves bit 3 clear.
- R4: The acknowledge limit is `count * prescale` cycles. The count sits in timer register (offset 2) bits [7:0] and the prescale in bits [11:8]. If `txn_ack` is not sampled on any of the limit edges after the start edge, status bit 0 is set on the last of those edges. An acknowledge sampled on any of those edges, including the last one, prevents it. A limit of 0 turns the watchdog off.
- R5: A transaction to an unmapped address is not ended by the block. Without an acknowledge it sets both bit 6 and bit 0.
- R6: After an atomic read that selects a bank, a write to that bank must be sampled within the next 256 edges. Otherwise status bit 4 is set on the 256th edge.
- R7: After an atomic write that selects a bank, a read of that bank must be sampled within the next 256 edges. Otherwise status bit 5 is set on the 256th edge. Accesses to other banks do not satisfy it.
- R8: `par_err` sets status bit 2. While bit 2 is clear, the same edge also captures the lane into attribute register (offset 3) bits [7:0] and the current bank into bits [15:8]. While bit 2 is set, the capture does not change.
- R9: `run_done` sets bit 7, `cmd_done` sets bit 8 and `cmd_tmo` sets bit 1.
- R10: Status (offset 0) is cleared by writing 1 to a bit. Writing 0 leaves the bit as it is. A set in the same cycle as a clear wins.
- R11: `irq` is high exactly when some status bit and the same bit of the enable register (offset 1) are both 1.
- R12: After reset, status, enable, timer and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | One-cycle pulse marking the start of a transaction |
| txn_addr | input | ADDR_W | Transaction address |
| txn_wr | input | 1 | 1 for a write, 0 for a read |
| txn_atomic | input | 1 | Transaction is an atomic access |
| txn_ack | input | 1 | Data beat acknowledged |
| par_err | input | 1 | Parity error pulse |
| par_lane | input | LANE_W | Byte lane of the parity error |
| run_done | input | 1 | Run-pattern operation finished |
| cmd_done | input | 1 | Flash command finished |
| cmd_tmo | input | 1 | Flash command over its time limit |
| bank_base | input | NBANK*ADDR_W | Bank bases, bank i at [i*ADDR_W +: ADDR_W] |
| bank_mask | input | NBANK*ADDR_W | Bank masks, same packing |
| bank_ro | input | NBANK | Read-only bit per bank |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench hits addresses that match two overlapping banks. A decoder that let the higher bank win would miss the write-protect flag and capture the wrong bank index. The acknowledge and atomic windows are each tested one cycle short of expiry, on expiry, and with the answer arriving on the very last allowed edge. An off-by-one counter would flag too early, too late, or flag a sequence that completed in time. Parity capture is hit twice before a clear and once after, which exposes capture registers that overwrite. A flag set in the same cycle as its clear would be lost by a block that gave the clear priority.

// File: rtl/lbem_pkg.sv
package lbem_pkg;
   // status bit positions
   localparam int ST_ACK_TMO  = 0;
   localparam int ST_CMD_TMO  = 1;
   localparam int ST_PARITY   = 2;
   localparam int ST_WPROT    = 3;
   localparam int ST_ATOM_WR  = 4;
   localparam int ST_ATOM_RD  = 5;
   localparam int ST_UNMAP    = 6;
   localparam int ST_RUN_DONE = 7;
   localparam int ST_CMD_DONE = 8;
   localparam int NSTAT       = 9;

   // register word offsets
   localparam logic [1:0] RA_STATUS = 2'd0;
   localparam logic [1:0] RA_ENABLE = 2'd1;
   localparam logic [1:0] RA_TIMER  = 2'd2;
   localparam logic [1:0] RA_ATTR   = 2'd3;
endpackage

// File: rtl/lbem_bank_dec.sv
module lbem_bank_dec #(
   parameter int ADDR_W = 32,
   parameter int NBANK  = 4,
   parameter int BANK_W = 2
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [NBANK*ADDR_W-1:0] base_flat,
   input  logic [NBANK*ADDR_W-1:0] mask_flat,
   output logic                    hit,
   output logic [BANK_W-1:0]       bank_idx
);
   logic [NBANK-1:0] hit_vec;

   for (genvar g = 0; g < NBANK; g++) begin : g_cmp
      assign hit_vec[g] = ((addr & mask_flat[g*ADDR_W +: ADDR_W]) ==
                           base_flat[g*ADDR_W +: ADDR_W]);
   end

   // scan from the top so the lowest matching bank is written last
   always_comb begin
      bank_idx = '0;
      for (int i = NBANK - 1; i >= 0; i--) begin
         if (hit_vec[i]) bank_idx = BANK_W'(i);
      end
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/lbem_ack_wd.sv
module lbem_ack_wd #(
   parameter int LIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ack,
   input  logic [LIM_W-1:0] limit,
   output logic             tmo_o
);
   logic             busy;
   logic [LIM_W-1:0] cnt;
   logic             at_lim;

   assign at_lim = (limit != '0) && (cnt >= limit - LIM_W'(1));
   assign tmo_o  = busy && !ack && at_lim;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= (limit != '0);
         cnt  <= '0;
      end else if (busy) begin
         if (ack || at_lim) busy <= 1'b0;
         else               cnt  <= cnt + LIM_W'(1);
      end
   end

   assert_wd_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && limit != '0) |=> (busy && cnt == '0));
   assert_wd_ack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ack && !start) |=> !busy);
endmodule

// File: rtl/lbem_atom_win.sv
module lbem_atom_win #(
   parameter int BANK_W = 2,
   parameter int WIN    = 256,
   localparam int CW    = $clog2(WIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              hit,
   input  logic              wr,
   input  logic              atomic,
   input  logic [BANK_W-1:0] bank,
   output logic              err_wr,
   output logic              err_rd
);
   logic              active;
   logic              by_read;
   logic [BANK_W-1:0] rbank;
   logic [CW-1:0]     cnt;
   logic              complement;
   logic              expire;
   logic              reserve;

   // a read reservation waits for a write, a write reservation for a read
   assign complement = start && hit && active && (bank == rbank) && (wr == by_read);
   assign reserve    = start && hit && atomic && !complement;
   assign expire     = active && !complement && (cnt == CW'(WIN - 1));
   assign err_wr     = expire && by_read;
   assign err_rd     = expire && !by_read;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         by_read <= 1'b0;
         rbank   <= '0;
         cnt     <= '0;
      end else if (complement) begin
         active <= 1'b0;
      end else if (reserve) begin
         active  <= 1'b1;
         by_read <= !wr;
         rbank   <= bank;
         cnt     <= '0;
      end else if (expire) begin
         active <= 1'b0;
      end else if (active) begin
         cnt <= cnt + CW'(1);
      end
   end

   assert_atom_reserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reserve |=> (active && cnt == '0));
   assert_atom_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_wr || err_rd) |=> (!active || cnt == '0));
endmodule

// File: rtl/lbus_err_mon.sv
module lbus_err_mon import lbem_pkg::*; #(
   parameter int ADDR_W   = 32,
   parameter int NBANK    = 4,
   parameter int CNT_W    = 8,
   parameter int PS_W     = 4,
   parameter int LANES    = 4,
   parameter int ATOM_WIN = 256,
   parameter int DATA_W   = 32,
   localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    txn_start,
   input  logic [ADDR_W-1:0]       txn_addr,
   input  logic                    txn_wr,
   input  logic                    txn_atomic,
   input  logic                    txn_ack,
   input  logic                    par_err,
   input  logic [LANE_W-1:0]       par_lane,
   input  logic                    run_done,
   input  logic                    cmd_done,
   input  logic                    cmd_tmo,
   input  logic [NBANK*ADDR_W-1:0] bank_base,
   input  logic [NBANK*ADDR_W-1:0] bank_mask,
   input  logic [NBANK-1:0]        bank_ro,
   input  logic                    reg_wr,
   input  logic [1:0]              reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   output logic                    irq
);
   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
   localparam int TW     = CNT_W + PS_W;
   localparam int LIM_W  = CNT_W + PS_W;

   if (NBANK < 1 || NBANK > 256) begin : g_bad_nbank
      $error("NBANK out of range");
   end
   if (LANES < 2 || LANES > 256) begin : g_bad_lanes
      $error("LANES out of range");
   end
   if (DATA_W < 16 || DATA_W < TW || DATA_W < NSTAT) begin : g_bad_data
      $error("DATA_W too narrow");
   end
   if (ATOM_WIN < 2) begin : g_bad_win
      $error("ATOM_WIN too small");
   end

   logic              dec_hit;
   logic [BANK_W-1:0] dec_bank;
   logic              wd_tmo;
   logic              aw_err_wr;
   logic              aw_err_rd;
   logic [NSTAT-1:0]  status_q, enable_q, set_v, clr_v;
   logic [CNT_W-1:0]  tcount_q;
   logic [PS_W-1:0]   tpre_q;
   logic [LIM_W-1:0]  limit;
   logic [BANK_W-1:0] cur_bank_q;
   logic [LANE_W-1:0] att_lane_q;
   logic [BANK_W-1:0] att_bank_q;
   logic              unused_wdata;

   lbem_bank_dec #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
      .addr(txn_addr), .base_flat(bank_base), .mask_flat(bank_mask),
      .hit(dec_hit), .bank_idx(dec_bank));

   assign limit = LIM_W'(tcount_q) * LIM_W'(tpre_q);

   lbem_ack_wd #(.LIM_W(LIM_W)) u_wd (
      .clk(clk), .rst_n(rst_n), .start(txn_start), .ack(txn_ack),
      .limit(limit), .tmo_o(wd_tmo));

   lbem_atom_win #(.BANK_W(BANK_W), .WIN(ATOM_WIN)) u_aw (
      .clk(clk), .rst_n(rst_n), .start(txn_start), .hit(dec_hit),
      .wr(txn_wr), .atomic(txn_atomic), .bank(dec_bank),
      .err_wr(aw_err_wr), .err_rd(aw_err_rd));

   always_comb begin
      set_v              = '0;
      set_v[ST_ACK_TMO]  = wd_tmo;
      set_v[ST_CMD_TMO]  = cmd_tmo;
      set_v[ST_PARITY]   = par_err;
      set_v[ST_WPROT]    = txn_start && dec_hit && txn_wr && bank_ro[dec_bank];
      set_v[ST_ATOM_WR]  = aw_err_wr;
      set_v[ST_ATOM_RD]  = aw_err_rd;
      set_v[ST_UNMAP]    = txn_start && !dec_hit;
      set_v[ST_RUN_DONE] = run_done;
      set_v[ST_CMD_DONE] = cmd_done;
   end

   assign clr_v = (reg_wr && reg_addr == RA_STATUS) ? reg_wdata[NSTAT-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q   <= '0;
         enable_q   <= '0;
         tcount_q   <= '0;
         tpre_q     <= '0;
         cur_bank_q <= '0;
         att_lane_q <= '0;
         att_bank_q <= '0;
      end else begin
         status_q <= (status_q & ~clr_v) | set_v;
         if (reg_wr && reg_addr == RA_ENABLE) enable_q <= reg_wdata[NSTAT-1:0];
         if (reg_wr && reg_addr == RA_TIMER) begin
            tcount_q <= reg_wdata[CNT_W-1:0];
            tpre_q   <= reg_wdata[TW-1:CNT_W];
         end
         if (txn_start && dec_hit) cur_bank_q <= dec_bank;
         if (par_err && !status_q[ST_PARITY]) begin
            att_lane_q <= par_lane;
            att_bank_q <= cur_bank_q;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_STATUS: reg_rdata[NSTAT-1:0] = status_q;
         RA_ENABLE: reg_rdata[NSTAT-1:0] = enable_q;
         RA_TIMER:  reg_rdata[TW-1:0]    = {tpre_q, tcount_q};
         default: begin
            reg_rdata[LANE_W-1:0]   = att_lane_q;
            reg_rdata[8 +: BANK_W]  = att_bank_q;
         end
      endcase
   end

   assign irq = |(status_q & enable_q);

   assign unused_wdata = ^reg_wdata[DATA_W-1:TW];

   assert_unmap_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_start && !dec_hit) |=> status_q[ST_UNMAP]);
   assert_sel_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_start && dec_hit) |->
         ((txn_addr & bank_mask[int'(dec_bank)*ADDR_W +: ADDR_W]) ==
          bank_base[int'(dec_bank)*ADDR_W +: ADDR_W]));
   assert_wprot_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_start && dec_hit && txn_wr && bank_ro[dec_bank]) |=> status_q[ST_WPROT]);
   assert_attr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[ST_PARITY] && !clr_v[ST_PARITY]) |=>
         ($stable(att_lane_q) && $stable(att_bank_q)));
   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[ST_CMD_DONE] && !clr_v[ST_CMD_DONE]) |=> status_q[ST_CMD_DONE]);
endmodule

// File: tb/sim_lbus_err_mon.sv
module sim_lbus_err_mon;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          txn_start = 0, txn_wr = 0, txn_atomic = 0, txn_ack = 0;
   logic [31:0]   txn_addr = '0;
   logic          par_err = 0, run_done = 0, cmd_done = 0, cmd_tmo = 0;
   logic [1:0]    par_lane = '0;
   logic [NB*32-1:0] bank_base, bank_mask;
   logic [NB-1:0] bank_ro;
   logic          reg_wr = 0;
   logic [1:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq;

   int chk_cnt = 0;
   int fail_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lbus_err_mon u0 (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
      .txn_wr(txn_wr), .txn_atomic(txn_atomic), .txn_ack(txn_ack),
      .par_err(par_err), .par_lane(par_lane), .run_done(run_done),
      .cmd_done(cmd_done), .cmd_tmo(cmd_tmo), .bank_base(bank_base),
      .bank_mask(bank_mask), .bank_ro(bank_ro), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq));

   // bank0 0x1xxxxxxx rw, bank1 0x2xxxxxxx ro, bank2 0x20xxxxxx rw (overlaps 1), bank3 0x3xxxxxxx rw
   assign bank_base = {32'h3000_0000, 32'h2000_0000, 32'h2000_0000, 32'h1000_0000};
   assign bank_mask = {32'hF000_0000, 32'hFF00_0000, 32'hF000_0000, 32'hF000_0000};
   assign bank_ro   = 4'b0010;

   // {addr, wr, expect unmapped, expect write-protect}
   localparam logic [34:0] VEC [0:7] = '{
      {32'h1000_0040, 1'b0, 1'b0, 1'b0},
      {32'h1000_0040, 1'b1, 1'b0, 1'b0},
      {32'h2000_1234, 1'b1, 1'b0, 1'b1},
      {32'h2000_1234, 1'b0, 1'b0, 1'b0},
      {32'h3ABC_0000, 1'b1, 1'b0, 1'b0},
      {32'h5000_0000, 1'b0, 1'b1, 1'b0},
      {32'h0000_0000, 1'b1, 1'b1, 1'b0},
      {32'h2100_0000, 1'b1, 1'b0, 1'b1}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      chk_cnt++;
      if (!ok) begin
         fail_cnt++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic issue(input logic [31:0] a, input logic w, input logic at);
      txn_start = 1'b1; txn_addr = a; txn_wr = w; txn_atomic = at;
      @(negedge clk);
      txn_start = 1'b0; txn_atomic = 1'b0;
   endtask

   task automatic par_pulse(input logic [1:0] lane);
      par_err = 1'b1; par_lane = lane;
      @(negedge clk);
      par_err = 1'b0;
   endtask

   task automatic finish_run;
      $display("  TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fail_cnt++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      logic [31:0] d;
      waitn(3);
      rst_n = 1'b1;
      waitn(1);

      // R12 reset state
      rd(2'd0, d); chk(d == 0, "R12 status", d, 0);
      rd(2'd1, d); chk(d == 0, "R12 enable", d, 0);
      rd(2'd2, d); chk(d == 0, "R12 timer", d, 0);
      chk(irq == 1'b0, "R12 irq", {31'd0, irq}, 0);

      // R1 R2 R3 decode vectors (watchdog off)
      for (int i = 0; i < 8; i++) begin
         wreg(2'd0, 32'h1FF);
         issue(VEC[i][34:3], VEC[i][2], 1'b0);
         rd(2'd0, d);
         chk(d[6] == VEC[i][1], "R1 unmapped", {31'd0, d[6]}, {31'd0, VEC[i][1]});
         chk(d[3] == VEC[i][0], "R3/R2 write-protect", {31'd0, d[3]}, {31'd0, VEC[i][0]});
      end

      // R8 parity capture, bank from overlapping match (R2)
      wreg(2'd0, 32'h1FF);
      issue(32'h2000_0010, 1'b0, 1'b0);
      par_pulse(2'd2);
      rd(2'd0, d); chk(d[2] == 1'b1, "R8 parity flag", d, 32'h4);
      rd(2'd3, d); chk(d == 32'h102, "R8/R2 capture", d, 32'h102);
      issue(32'h3000_0000, 1'b0, 1'b0);
      par_pulse(2'd1);
      rd(2'd3, d); chk(d == 32'h102, "R8 hold", d, 32'h102);
      wreg(2'd0, 32'h4);
      par_pulse(2'd3);
      rd(2'd3, d); chk(d == 32'h303, "R8 recapture", d, 32'h303);

      // R4 acknowledge watchdog, limit 5*2 = 10
      wreg(2'd2, 32'h205);
      wreg(2'd0, 32'h1FF);
      issue(32'h1000_0000, 1'b0, 1'b0);
      waitn(9);
      rd(2'd0, d); chk(d[0] == 1'b0, "R4 before limit", d, 0);
      waitn(1);
      rd(2'd0, d); chk(d[0] == 1'b1, "R4 at limit", d, 32'h1);

      wreg(2'd0, 32'h1FF);
      issue(32'h1000_0000, 1'b0, 1'b0);
      waitn(9);
      txn_ack = 1'b1; @(negedge clk); txn_ack = 1'b0;
      waitn(20);
      rd(2'd0, d); chk(d[0] == 1'b0, "R4 ack on last edge", d, 0);

      // R5 unmapped also times out
      wreg(2'd0, 32'h1FF);
      issue(32'h5000_0000, 1'b1, 1'b0);
      waitn(10);
      rd(2'd0, d); chk((d & 32'h41) == 32'h41, "R5 unmapped timeout", d & 32'h41, 32'h41);

      // R4 limit zero disables
      wreg(2'd2, 32'h0);
      wreg(2'd0, 32'h1FF);
      issue(32'h1000_0000, 1'b0, 1'b0);
      waitn(40);
      rd(2'd0, d); chk(d[0] == 1'b0, "R4 disabled", d, 0);

      // R6 atomic read without write
      wreg(2'd0, 32'h1FF);
      issue(32'h1000_0000, 1'b0, 1'b1);
      waitn(255);
      rd(2'd0, d); chk(d[4] == 1'b0, "R6 before window end", d, 0);
      waitn(1);
      rd(2'd0, d); chk(d[4] == 1'b1, "R6 expired", d, 32'h10);

      // R6 write on the last allowed edge
      wreg(2'd0, 32'h1FF);
      issue(32'h1000_0000, 1'b0, 1'b1);
      waitn(255);
      issue(32'h1000_0100, 1'b1, 1'b0);
      waitn(20);
      rd(2'd0, d); chk(d[4] == 1'b0, "R6 met at boundary", d, 0);

      // R7 atomic write, read to another bank does not count
      wreg(2'd0, 32'h1FF);
      issue(32'h3000_0000, 1'b1, 1'b1);
      waitn(100);
      issue(32'h1000_0000, 1'b0, 1'b0);
      waitn(154);
      rd(2'd0, d); chk(d[5] == 1'b0, "R7 before window end", d, 0);
      waitn(1);
      rd(2'd0, d); chk(d[5:4] == 2'b10, "R7 expired", {30'd0, d[5:4]}, 32'h2);

      // R9 event flags
      wreg(2'd0, 32'h1FF);
      run_done = 1'b1; cmd_done = 1'b1; cmd_tmo = 1'b1;
      @(negedge clk);
      run_done = 1'b0; cmd_done = 1'b0; cmd_tmo = 1'b0;
      rd(2'd0, d); chk(d == 32'h182, "R9 events", d, 32'h182);

      // R11 gating with enable zero
      chk(irq == 1'b0, "R11 disabled", {31'd0, irq}, 0);

      // R10 write-one-to-clear
      wreg(2'd0, 32'h0);
      rd(2'd0, d); chk(d == 32'h182, "R10 write zero", d, 32'h182);
      wreg(2'd1, 32'h80);
      chk(irq == 1'b1, "R11 enabled flag", {31'd0, irq}, 1);
      wreg(2'd0, 32'h80);
      rd(2'd0, d); chk(d == 32'h102, "R10 clear one bit", d, 32'h102);
      chk(irq == 1'b0, "R11 after clear", {31'd0, irq}, 0);
      run_done = 1'b1;
      wreg(2'd0, 32'h80);
      run_done = 1'b0;
      rd(2'd0, d); chk(d[7] == 1'b1, "R10 set wins", d, 32'h182);
      wreg(2'd1, 32'h100);
      chk(irq == 1'b1, "R11 other bit", {31'd0, irq}, 1);

      finish_run();
   end
endmodule